// File: doc/BRIEF.md
# Fractional-Rate Hold Counter

This block is an 8-bit up-counter that advances at an average rate of `rate_num / rate_den` steps per clock. Each count value is therefore held for `rate_den / rate_num` clocks on average, and that average may be fractional. A phase accumulator adds `rate_num` on every clock. When the sum reaches or passes the modulus `rate_den`, the accumulator subtracts the modulus, the count steps by one, and a one-cycle `advance` strobe marks the step.

The modulus does not have to be a power of two, and any value up to 1023 may be used. If the true hold time is not a whole number of clocks, the individual holds switch between the two nearest integers, so the long-run average is exact. Both rate inputs are plain control levels. They are expected to stay stable between resets. Neither the ports nor the design have a stream interface, so the design has no valid/ready handshake and no back-pressure.

Top module: `frh_counter`

## Requirements
- R1: A synchronous reset sets `hold_count` to 0, `advance` to 0 and the phase accumulator to 0. These values are seen in the cycle after the reset edge.
- R2: Let n be the number of clock edges since reset was released, with constant `rate_num` ≤ `rate_den` and `rate_den` > 0. Then `hold_count` equals floor(n·rate_num/rate_den) mod 256, exactly.
- R3: `advance` is high for exactly one cycle after each edge at which accumulator + `rate_num` ≥ `rate_den`. At that same edge `hold_count` rises by one. Outside a reset, `hold_count` never changes in a cycle where `advance` is low.
- R4: When `rate_num` equals `rate_den`, `advance` is high after every clock edge.
- R5: When `rate_num` is 0 and `rate_den` is nonzero, `hold_count` never advances.
- R6: `hold_count` steps from 255 to 0 on an advance.
- R7: With `rate_den` = 512 and `rate_num` = 40, every hold between successive advances is 12 or 13 clocks.
- R8: A `rate_num` larger than `rate_den` is treated as equal to `rate_den`, so the count advances on every clock.
- R9: A non-power-of-two modulus works. With `rate_den` = 460 and `rate_num` = 1, the first advance follows the 460th edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rate_num | input | 10 | Phase increment added every clock |
| rate_den | input | 10 | Accumulator modulus |
| hold_count | output | 8 | Current count value |
| advance | output | 1 | One-cycle strobe for each count step |

## Verification
Two events can fall in the same cycle: the count wrapping from 255 to 0, and an advance strobe. The bench sets `rate_num` equal to `rate_den` with a modulus of 460, so the count strobes on every clock and crosses 255 after the 256th edge. The per-cycle scoreboard expects a count of 0 with `advance` high in that cycle. A reset is also applied between runs while strobes are firing. The first sample after that reset must show a count of zero and no strobe.

// File: rtl/frh_pkg.sv
package frh_pkg;
  parameter int PHASE_W = 10;
  parameter int COUNT_W = 8;
  localparam int SUM_W = PHASE_W + 1;
  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [SUM_W-1:0]   sum_t;
  typedef logic [COUNT_W-1:0] count_t;
endpackage

// File: rtl/frh_phase_acc.sv
module frh_phase_acc
  import frh_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t inc,
  input  phase_t modulus,
  output logic   step,
  output logic   strobe
);
  phase_t acc_q;
  phase_t inc_eff;
  sum_t   sum;
  sum_t   wrapped;
  logic   hit;

  // increment clamped to the modulus (R8)
  always_comb begin
    inc_eff = (inc > modulus) ? modulus : inc;
    sum     = {1'b0, acc_q} + {1'b0, inc_eff};
    hit     = (sum >= {1'b0, modulus});
    wrapped = sum - {1'b0, modulus};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      strobe <= 1'b0;
    end else begin
      acc_q  <= hit ? wrapped[PHASE_W-1:0] : sum[PHASE_W-1:0];
      strobe <= hit;
    end
  end

  assign step = hit & ~rst;
endmodule

// File: rtl/frh_step_counter.sv
module frh_step_counter
  import frh_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step,
  output count_t value
);
  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (step) value <= value + 1'b1;
  end
endmodule

// File: rtl/frh_counter.sv
module frh_counter
  import frh_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] rate_num,
  input  logic [PHASE_W-1:0] rate_den,
  output logic [COUNT_W-1:0] hold_count,
  output logic               advance
);
  logic step;

  frh_phase_acc u_acc (
    .clk     (clk),
    .rst     (rst),
    .inc     (rate_num),
    .modulus (rate_den),
    .step    (step),
    .strobe  (advance)
  );

  frh_step_counter u_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .value (hold_count)
  );
endmodule

// File: rtl/frh_counter_chk.sv
module frh_counter_chk
  import frh_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] rate_num,
  input logic [PHASE_W-1:0] rate_den,
  input logic [COUNT_W-1:0] hold_count,
  input logic               advance
);
  logic rst_d = 1'b1;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (hold_count == '0 && !advance));

  // R3
  step_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_d && advance) |-> hold_count == COUNT_W'($past(hold_count) + 1'b1));

  // R3
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_d && !advance) |-> $stable(hold_count));

  // R4
  full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_num == rate_den) |=> advance);

  // R5
  zero_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_num == '0 && rate_den != '0) |=> !advance);

  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_d && advance && $past(hold_count) == '1) |-> hold_count == '0);

  // R8
  clamp_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_num > rate_den) |=> advance);
endmodule

bind frh_counter frh_counter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rate_num   (rate_num),
  .rate_den   (rate_den),
  .hold_count (hold_count),
  .advance    (advance)
);

// File: tb/frh_counter_test.sv
module frh_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] rate_num = '0;
  logic [9:0] rate_den = 10'd1;
  logic [7:0] hold_count;
  logic       advance;

  int tests = 0;
  int fails = 0;

  typedef struct { logic stb; logic [7:0] cnt; int n; string req; } exp_t;
  exp_t sb[$];

  logic gap_on = 1'b0;
  logic gap_seen = 1'b0;
  int   gap = 0;

  always #5 clk = ~clk;

  frh_counter uut (
    .clk(clk), .rst(rst), .rate_num(rate_num), .rate_den(rate_den),
    .hold_count(hold_count), .advance(advance)
  );

  // monitor: compare each produced cycle with the scoreboard
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (hold_count !== e.cnt || advance !== e.stb) begin
        fails++;
        $display("FAIL %s edge %0d: count=%0d adv=%b expected count=%0d adv=%b",
                 e.req, e.n, hold_count, advance, e.cnt, e.stb);
      end
    end
    if (gap_on) begin
      gap++;
      if (advance) begin
        if (gap_seen) begin
          tests++;
          if (gap != 12 && gap != 13) begin
            fails++;
            $display("FAIL R7 hold=%0d expected 12 or 13", gap);
          end
        end
        gap_seen = 1'b1;
        gap = 0;
      end
    end
  end

  task automatic do_reset(input logic [9:0] xn, input logic [9:0] yd);
    @(negedge clk);
    rst = 1'b1;
    rate_num = xn;
    rate_den = yd;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    tests++;
    if (hold_count !== 8'd0 || advance !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: count=%0d adv=%b expected count=0 adv=0",
               hold_count, advance);
    end
    rst = 1'b0;
  endtask

  // driver: push expected result of each edge, computed from floor(n*x/y)
  task automatic run_pair(input logic [9:0] xn, input logic [9:0] yd,
                          input int edges, input string req);
    longint xe;
    xe = (xn > yd) ? longint'(yd) : longint'(xn);
    do_reset(xn, yd);
    for (int n = 1; n <= edges; n++) begin
      longint cur, prv;
      exp_t e;
      cur = (longint'(n) * xe) / longint'(yd);
      prv = (longint'(n - 1) * xe) / longint'(yd);
      @(posedge clk);
      #1;
      e.stb = (cur != prv);
      e.cnt = cur[7:0];
      e.n   = n;
      e.req = req;
      sb.push_back(e);
    end
    @(negedge clk);
    #1;
  endtask

  initial begin
    // R2 R7: 40/512 gives 12.8-clock average hold
    gap_on = 1'b1; gap_seen = 1'b0; gap = 0;
    run_pair(10'd40, 10'd512, 3000, "R2/R7 40/512");
    gap_on = 1'b0;
    // R9: non-power-of-two modulus, first step after 460 edges
    run_pair(10'd1, 10'd460, 1000, "R9 1/460");
    // R2: power-of-two slowest rate
    run_pair(10'd1, 10'd512, 1100, "R2 1/512");
    // R2: odd ratio
    run_pair(10'd7, 10'd460, 1500, "R2 7/460");
    // R4 R6: full rate, wrap 255->0 coincides with a strobe
    run_pair(10'd460, 10'd460, 300, "R4/R6 460/460");
    // R5: zero rate never steps
    run_pair(10'd0, 10'd300, 400, "R5 0/300");
    // R8: num above den clamps to full rate
    run_pair(10'd600, 10'd460, 80, "R8 600/460");
    // R3: reset mid-run is covered by do_reset at the next call
    run_pair(10'd3, 10'd10, 50, "R3 3/10");
    do_reset(10'd3, 10'd10);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule